// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block is the target side of a parallel SCSI link for one logical unit. It watches for a selection that carries its own ID and then takes the bus. It drives the information-transfer phases in order: an optional message from the initiator, the command descriptor bytes, an optional data phase, one status byte, one message byte, and then it releases the bus. Command, status and message bytes use the REQ/ACK handshake. Data bytes use a separate request/acknowledge pair, as a DMA engine would.

A small set of commands is decoded. The first command byte gives the descriptor length and the operation. Read and write commands produce a start block address and a byte count for a block store. That store sits outside the block and is reached through a byte-index port. Commands the block does not know, and inquiries aimed at a nonzero logical unit, end with a check-condition status.

Top module: `scsi_tgt_seq`

## Requirements
- R1: After reset, `bsy`, `req` and `dma_req` are low and `phase` reads 000.
- R2: While `sel` is high and `dbus_in` bit `TGT_ID` is set, the block raises `bsy` and presets the status to 0x00. With `atn` high it enters message-out (`phase` 110); with `atn` low it enters command (`phase` 010). A selection without that ID bit is ignored. `phase` is {MSG, C/D, I/O}: data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111.
- R3: In message-out, command, status and message-in, `req` rises while `ack` is low. A byte is taken on the clock where `req` and `ack` are both high, and `req` then drops. The message-out byte is discarded and the block moves to command.
- R4: Bits 7:5 of the first command byte set the descriptor length: group 0 is 6 bytes, groups 1 and 2 are 10 bytes, group 5 is 12 bytes. The other groups take 6 bytes and end in check condition.
- R5: READ(6), opcode 0x08, enters data-in. Its start block is {byte1[4:0], byte2, byte3} and its length is byte4 × 512 bytes.
- R6: READ(10), opcode 0x28, and WRITE(10), opcode 0x2A, take the start block from bytes 2..5 (byte 2 most significant) and the block count from {byte7, byte8}, at 512 bytes per block. READ enters data-in. WRITE enters data-out and pulses `med_wr` once per byte, with that byte on `med_wdata`.
- R7: TEST UNIT READY (0x00) goes straight to status. REQUEST SENSE (0x03), INQUIRY (0x12) and MODE SENSE (0x1A) enter data-in with a length of byte4 bytes. MODE SELECT (0x15) enters data-out with a length of byte4 bytes and never pulses `med_wr`.
- R8: READ CAPACITY (0x25) always sends 8 bytes: 00 01 00 00 00 00 02 00.
- R9: An unsupported opcode goes straight to status with status 0x02. INQUIRY with a nonzero byte1[7:5] still transfers its data and then returns status 0x02.
- R10: In a data phase, `dma_req` rises while `dma_ack` is low. A byte completes on the clock where both are high, and `dma_req` then drops. After the last byte, `req` drops and the block enters status. A decoded length of zero goes directly to status.
- R11: The status phase sends the status code on `dbus_out`. Message-in then sends the same code. Once that byte is acknowledged, `bsy` falls and the bus is free.
- R12: `bus_rst` forces the bus-free state on the next clock and clears `bsy`, `req` and `dma_req`.
- R13: In data-in for a read, a byte is `med_rdata` at index `med_idx` when `med_present` is high, and 0x00 when it is low. Generated responses other than READ CAPACITY are zero bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Bus reset from the initiator |
| sel | input | 1 | Selection line |
| atn | input | 1 | Attention line, sampled at selection |
| ack | input | 1 | Byte acknowledge from the initiator |
| dbus_in | input | 8 | Byte from the initiator |
| dbus_out | output | 8 | Byte to the initiator |
| bsy | output | 1 | Target holds the bus |
| req | output | 1 | Byte request |
| phase | output | 3 | {MSG, C/D, I/O} of the current phase |
| dma_req | output | 1 | Data byte request |
| dma_ack | input | 1 | Data byte acknowledge |
| med_present | input | 1 | Block store attached |
| med_lba | output | 32 | Start block of the current transfer |
| med_idx | output | LEN_W | Byte index within the transfer |
| med_rdata | input | 8 | Store byte at med_lba/med_idx |
| med_wr | output | 1 | Store write strobe |
| med_wdata | output | 8 | Store write byte |

## Verification
The assertions assume an initiator that raises `ack` only after it sees `req`, and holds `ack` low during data phases. They also assume `dma_ack` is raised only in answer to `dma_req`, and that bytes on `dbus_in` stay stable while their acknowledge is high. The bench keeps to this. Every exchange goes through tasks that wait for the request on a falling edge, present the byte and raise the acknowledge, then drop it once the request falls. Bus reset is applied only while no acknowledge is held.

// File: rtl/tps_pkg.sv
package tps_pkg;

   // phase encoding: bit3 marks a non-transfer state, bits 2:0 are {MSG, C/D, I/O}
   typedef enum logic [3:0] {
      PH_DOUT = 4'd0,
      PH_DIN  = 4'd1,
      PH_CMD  = 4'd2,
      PH_STAT = 4'd3,
      PH_MOUT = 4'd6,
      PH_MIN  = 4'd7,
      PH_FREE = 4'd8,
      PH_SEL  = 4'd9
   } tps_state_e;

   typedef enum logic [1:0] {
      SRC_ZERO     = 2'd0,
      SRC_MEDIUM   = 2'd1,
      SRC_CAPACITY = 2'd2
   } tps_src_e;

   typedef struct packed {
      tps_state_e  next;
      logic        check;
      tps_src_e    src;
      logic        wr_medium;
      logic [31:0] lba;
   } tps_cmd_t;

   localparam logic [7:0] ST_GOOD  = 8'h00;
   localparam logic [7:0] ST_CHECK = 8'h02;
   localparam int         CDB_KEEP = 10;

   function automatic logic [3:0] cdb_need(input logic [2:0] grp);
      case (grp)
         3'd1, 3'd2: cdb_need = 4'd10;
         3'd5:       cdb_need = 4'd12;
         default:    cdb_need = 4'd6;
      endcase
   endfunction

   function automatic logic [7:0] capacity_byte(input logic [2:0] idx);
      case (idx)
         3'd1:    capacity_byte = 8'h01;
         3'd6:    capacity_byte = 8'h02;
         default: capacity_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/tps_decode.sv
module tps_decode
   import tps_pkg::*;
#(
   parameter int LEN_W     = 25,
   parameter int BLK_SHIFT = 9
) (
   input  logic [0:CDB_KEEP-1][7:0] cdb,
   output tps_cmd_t                 cmd,
   output logic [LEN_W-1:0]         len
);

   logic [15:0]      blk10;
   logic [LEN_W-1:0] len10;
   logic [LEN_W-1:0] len6;
   logic [LEN_W-1:0] len_b4;
   logic             unused_cdb;

   assign blk10      = {cdb[7], cdb[8]};
   assign len10      = LEN_W'(blk10) << BLK_SHIFT;
   assign len6       = LEN_W'(cdb[4]) << BLK_SHIFT;
   assign len_b4     = LEN_W'(cdb[4]);
   assign unused_cdb = ^{cdb[6], cdb[9]};

   always_comb begin
      cmd.next      = PH_STAT;
      cmd.check     = 1'b1;
      cmd.src       = SRC_ZERO;
      cmd.wr_medium = 1'b0;
      cmd.lba       = '0;
      len           = '0;
      case (cdb[0])
         8'h00: cmd.check = 1'b0;
         8'h03, 8'h1A: begin
            cmd.next  = PH_DIN;
            cmd.check = 1'b0;
            len       = len_b4;
         end
         8'h08: begin
            cmd.next  = PH_DIN;
            cmd.check = 1'b0;
            cmd.src   = SRC_MEDIUM;
            cmd.lba   = {11'd0, cdb[1][4:0], cdb[2], cdb[3]};
            len       = len6;
         end
         8'h12: begin
            cmd.next  = PH_DIN;
            cmd.check = (cdb[1][7:5] != 3'd0);
            len       = len_b4;
         end
         8'h15: begin
            cmd.next  = PH_DOUT;
            cmd.check = 1'b0;
            len       = len_b4;
         end
         8'h25: begin
            cmd.next  = PH_DIN;
            cmd.check = 1'b0;
            cmd.src   = SRC_CAPACITY;
            len       = LEN_W'(8);
         end
         8'h28, 8'h2A: begin
            cmd.next      = cdb[0][1] ? PH_DOUT : PH_DIN;
            cmd.check     = 1'b0;
            cmd.src       = SRC_MEDIUM;
            cmd.wr_medium = cdb[0][1];
            cmd.lba       = {cdb[2], cdb[3], cdb[4], cdb[5]};
            len           = len10;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tps_xfer_cnt.sv
module tps_xfer_cnt #(
   parameter int LEN_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             step,
   output logic [LEN_W-1:0] index,
   output logic             last
);

   logic [LEN_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         index    <= '0;
      end else if (load) begin
         remain_q <= load_val;
         index    <= '0;
      end else if (step) begin
         remain_q <= remain_q - 1'b1;
         index    <= index + 1'b1;
      end
   end

   assign last = (remain_q == LEN_W'(1));

endmodule

// File: rtl/scsi_tgt_seq.sv
module scsi_tgt_seq
   import tps_pkg::*;
#(
   parameter int TGT_ID    = 6,
   parameter int BLK_BYTES = 512,
   parameter int BLK_SHIFT = $clog2(BLK_BYTES),
   parameter int LEN_W     = 16 + BLK_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             sel,
   input  logic             atn,
   input  logic             ack,
   input  logic [7:0]       dbus_in,
   output logic [7:0]       dbus_out,
   output logic             bsy,
   output logic             req,
   output logic [2:0]       phase,
   output logic             dma_req,
   input  logic             dma_ack,
   input  logic             med_present,
   output logic [31:0]      med_lba,
   output logic [LEN_W-1:0] med_idx,
   input  logic [7:0]       med_rdata,
   output logic             med_wr,
   output logic [7:0]       med_wdata
);

   localparam int CNT_W = 4;

   if (TGT_ID < 0 || TGT_ID > 7) begin : g_bad_id
      $error("TGT_ID must select one of the eight data lines");
   end
   if ((1 << BLK_SHIFT) != BLK_BYTES) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (LEN_W < 16 + BLK_SHIFT) begin : g_bad_len
      $error("LEN_W too narrow for a 16-bit block count");
   end

   tps_state_e               state_q;
   logic                     req_q, dreq_q, bsy_q, wr_q;
   logic [7:0]               status_q;
   logic [CNT_W-1:0]         cdb_n;
   tps_src_e                 src_q;
   logic [31:0]              lba_q;
   logic [0:CDB_KEEP-1][7:0] cdb_q;
   tps_cmd_t                 dec_cmd;
   logic [LEN_W-1:0]         dec_len;
   logic [LEN_W-1:0]         idx;
   logic                     last_byte;
   logic                     cmd_done, cap_en, dispatch, data_ph, xfer_step;

   assign cmd_done  = (cdb_n != '0) && (cdb_n == cdb_need(cdb_q[0][7:5]));
   assign cap_en    = !bus_rst && state_q == PH_CMD && !cmd_done && ack && req_q;
   assign dispatch  = !bus_rst && state_q == PH_CMD && cmd_done;
   assign data_ph   = (state_q == PH_DOUT) || (state_q == PH_DIN);
   assign xfer_step = !bus_rst && data_ph && dreq_q && dma_ack;

   // descriptor bytes beyond CDB_KEEP are counted but never decoded
   for (genvar i = 0; i < CDB_KEEP; i++) begin : g_cdb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cdb_q[i] <= '0;
         else if (cap_en && cdb_n == CNT_W'(i))
            cdb_q[i] <= dbus_in;
      end
   end

   tps_decode #(.LEN_W(LEN_W), .BLK_SHIFT(BLK_SHIFT)) u_dec (
      .cdb (cdb_q),
      .cmd (dec_cmd),
      .len (dec_len)
   );

   tps_xfer_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dispatch),
      .load_val (dec_len),
      .step     (xfer_step),
      .index    (idx),
      .last     (last_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_FREE;
         req_q    <= 1'b0;
         dreq_q   <= 1'b0;
         bsy_q    <= 1'b0;
         status_q <= ST_GOOD;
         cdb_n    <= '0;
         src_q    <= SRC_ZERO;
         wr_q     <= 1'b0;
         lba_q    <= '0;
      end else if (bus_rst) begin
         state_q <= PH_FREE;
         req_q   <= 1'b0;
         dreq_q  <= 1'b0;
         bsy_q   <= 1'b0;
         cdb_n   <= '0;
      end else begin
         case (state_q)
            PH_FREE: if (sel) state_q <= PH_SEL;
            PH_SEL: begin
               if (!sel)
                  state_q <= PH_FREE;
               else if (dbus_in[TGT_ID]) begin
                  bsy_q    <= 1'b1;
                  status_q <= ST_GOOD;
                  cdb_n    <= '0;
                  state_q  <= atn ? PH_MOUT : PH_CMD;
               end
            end
            PH_MOUT: begin
               if (!ack) req_q <= 1'b1;
               else if (req_q) begin
                  req_q   <= 1'b0;
                  state_q <= PH_CMD;
               end
            end
            PH_CMD: begin
               if (cmd_done) begin
                  cdb_n <= '0;
                  req_q <= 1'b0;
                  src_q <= dec_cmd.src;
                  wr_q  <= dec_cmd.wr_medium;
                  lba_q <= dec_cmd.lba;
                  if (dec_cmd.check) status_q <= ST_CHECK;
                  if (dec_cmd.next != PH_STAT && dec_len == '0)
                     state_q <= PH_STAT;
                  else
                     state_q <= dec_cmd.next;
               end else if (!ack)
                  req_q <= 1'b1;
               else if (req_q) begin
                  req_q <= 1'b0;
                  cdb_n <= cdb_n + 1'b1;
               end
            end
            PH_DOUT, PH_DIN: begin
               if (!ack) req_q <= 1'b1;
               if (xfer_step) begin
                  dreq_q <= 1'b0;
                  if (last_byte) begin
                     req_q   <= 1'b0;
                     state_q <= PH_STAT;
                  end
               end else if (!dma_ack)
                  dreq_q <= 1'b1;
            end
            PH_STAT: begin
               if (!ack) req_q <= 1'b1;
               else if (req_q) begin
                  req_q   <= 1'b0;
                  state_q <= PH_MIN;
               end
            end
            PH_MIN: begin
               if (!ack) req_q <= 1'b1;
               else if (req_q) begin
                  req_q   <= 1'b0;
                  bsy_q   <= 1'b0;
                  state_q <= PH_FREE;
               end
            end
            default: state_q <= PH_FREE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         PH_STAT, PH_MIN: dbus_out = status_q;
         PH_DIN: begin
            case (src_q)
               SRC_MEDIUM:   dbus_out = med_present ? med_rdata : 8'h00;
               SRC_CAPACITY: dbus_out = capacity_byte(idx[2:0]);
               default:      dbus_out = 8'h00;
            endcase
         end
         default: dbus_out = 8'h00;
      endcase
   end

   assign bsy       = bsy_q;
   assign req       = req_q;
   assign dma_req   = dreq_q;
   assign phase     = state_q[3] ? 3'b000 : state_q[2:0];
   assign med_lba   = lba_q;
   assign med_idx   = idx;
   assign med_wr    = xfer_step && wr_q && state_q == PH_DOUT;
   assign med_wdata = dbus_in;

endmodule

// File: rtl/scsi_tgt_seq_chk.sv
module scsi_tgt_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rst,
   input logic       sel,
   input logic       ack,
   input logic       bsy,
   input logic       req,
   input logic [2:0] phase,
   input logic       dma_req,
   input logic       dma_ack
);

   assert_req_needs_bsy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> bsy);

   assert_req_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack && phase[2:1] != 2'b00) |=> !req);

   assert_dma_in_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (bsy && phase[2:1] == 2'b00));

   assert_dma_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && dma_ack && !bus_rst) |=> !dma_req);

   assert_bus_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (!bsy && !req && !dma_req));

   assert_release_after_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bsy) |-> ($past(bus_rst) || $past(phase) == 3'b111));

   assert_busy_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bsy) |-> $past(sel));

endmodule

bind scsi_tgt_seq scsi_tgt_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_rst (bus_rst),
   .sel     (sel),
   .ack     (ack),
   .bsy     (bsy),
   .req     (req),
   .phase   (phase),
   .dma_req (dma_req),
   .dma_ack (dma_ack)
);

// File: tb/scsi_tgt_seq_test.sv
module scsi_tgt_seq_test;

   localparam int LEN_W = 25;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_rst = 1'b0, sel = 1'b0, atn = 1'b0, ack = 1'b0;
   logic [7:0]       dbus_in = 8'h00;
   logic [7:0]       dbus_out;
   logic             bsy, req, dma_req;
   logic [2:0]       phase;
   logic             dma_ack = 1'b0;
   logic             med_present = 1'b0;
   logic [31:0]      med_lba;
   logic [LEN_W-1:0] med_idx;
   logic [7:0]       med_rdata;
   logic             med_wr;
   logic [7:0]       med_wdata;

   int checks = 0, fails = 0, wr_count = 0;
   logic [7:0] last_wdata;
   bit done = 0;

   always #10 clk = ~clk;

   assign med_rdata = med_lba[7:0] + med_idx[7:0];

   scsi_tgt_seq uut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .sel(sel), .atn(atn),
      .ack(ack), .dbus_in(dbus_in), .dbus_out(dbus_out), .bsy(bsy), .req(req),
      .phase(phase), .dma_req(dma_req), .dma_ack(dma_ack),
      .med_present(med_present), .med_lba(med_lba), .med_idx(med_idx),
      .med_rdata(med_rdata), .med_wr(med_wr), .med_wdata(med_wdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int m_st, m_cnt, m_idx, m_src, m_status;
   bit m_req, m_dreq, m_bsy;
   logic [31:0] m_lba;
   logic [7:0] q[$];

   function automatic int need_of(input logic [7:0] b0);
      case (b0[7:5])
         3'd1, 3'd2: return 10;
         3'd5: return 12;
         default: return 6;
      endcase
   endfunction

   task automatic m_dispatch();
      int nxt = 3, len = 0, src = 0;
      bit c = 1;
      logic [31:0] l = 0;
      case (q[0])
         8'h00: c = 0;
         8'h03, 8'h1A: begin nxt = 1; len = q[4]; c = 0; end
         8'h08: begin nxt = 1; len = q[4] * 512; l = {11'd0, q[1][4:0], q[2], q[3]}; src = 1; c = 0; end
         8'h12: begin nxt = 1; len = q[4]; c = (q[1][7:5] != 0); end
         8'h15: begin nxt = 0; len = q[4]; c = 0; end
         8'h25: begin nxt = 1; len = 8; src = 2; c = 0; end
         8'h28, 8'h2A: begin
            nxt = (q[0] == 8'h28) ? 1 : 0; len = {q[7], q[8]} * 512;
            l = {q[2], q[3], q[4], q[5]}; src = 1; c = 0;
         end
         default: ;
      endcase
      if (c) m_status = 2;
      if (nxt < 2 && len == 0) nxt = 3;
      m_st = nxt; m_req = 0; m_cnt = len; m_idx = 0; m_src = src; m_lba = l;
      q.delete();
   endtask

   always @(posedge clk) begin
      if (!rst_n || bus_rst) begin
         if (!rst_n) begin m_status = 0; m_src = 0; m_lba = 0; end
         m_st = 8; m_req = 0; m_dreq = 0; m_bsy = 0; q.delete();
      end else begin
         case (m_st)
            8: if (sel) m_st = 9;
            9: if (!sel) m_st = 8;
               else if (dbus_in[6]) begin
                  m_bsy = 1; m_status = 0; q.delete(); m_st = atn ? 6 : 2;
               end
            6: if (!ack) m_req = 1; else if (m_req) begin m_req = 0; m_st = 2; end
            2: if (q.size() > 0 && q.size() == need_of(q[0])) m_dispatch();
               else if (!ack) m_req = 1;
               else if (m_req) begin q.push_back(dbus_in); m_req = 0; end
            0, 1: begin
               if (!ack) m_req = 1;
               if (m_dreq && dma_ack) begin
                  m_dreq = 0; m_cnt--; m_idx++;
                  if (m_cnt == 0) begin m_req = 0; m_st = 3; end
               end else if (!dma_ack) m_dreq = 1;
            end
            3: if (!ack) m_req = 1; else if (m_req) begin m_req = 0; m_st = 7; end
            7: if (!ack) m_req = 1; else if (m_req) begin m_req = 0; m_bsy = 0; m_st = 8; end
            default: m_st = 8;
         endcase
      end
      if (med_wr) begin wr_count++; last_wdata = med_wdata; end
   end

   function automatic logic [7:0] m_data();
      if (m_st == 3 || m_st == 7) return m_status[7:0];
      if (m_src == 1) return med_present ? (m_lba[7:0] + m_idx[7:0]) : 8'h00;
      if (m_src == 2) return (m_idx == 1) ? 8'h01 : (m_idx == 6) ? 8'h02 : 8'h00;
      return 8'h00;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 bsy vs model", bsy, m_bsy);
         chk("R3 req vs model", req, m_req);
         chk("R10 dma_req vs model", dma_req, m_dreq);
         chk("R2 phase vs model", phase, (m_st >= 8) ? 0 : m_st);
         if (((m_st == 3 || m_st == 7) && m_req) || (m_st == 1 && m_dreq))
            chk("R13 dbus_out vs model", dbus_out, m_data());
      end
   end

   // ---------------- initiator tasks ----------------
   task automatic wait_req();
      while (!req) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      wait_req();
      dbus_in = b; ack = 1;
      while (req) @(negedge clk);
      ack = 0;
      @(negedge clk);
   endtask

   task automatic get_byte(output logic [7:0] b);
      wait_req();
      b = dbus_out; ack = 1;
      while (req) @(negedge clk);
      ack = 0;
      @(negedge clk);
   endtask

   task automatic dma_in(output logic [7:0] b);
      while (!dma_req) @(negedge clk);
      b = dbus_out; dma_ack = 1;
      @(negedge clk);
      dma_ack = 0;
      @(negedge clk);
   endtask

   task automatic dma_out(input logic [7:0] b);
      while (!dma_req) @(negedge clk);
      dbus_in = b; dma_ack = 1;
      @(negedge clk);
      dma_ack = 0;
      @(negedge clk);
   endtask

   task automatic select(input logic with_atn);
      @(negedge clk);
      dbus_in = 8'h40; sel = 1; atn = with_atn;
      while (!bsy) @(negedge clk);
      sel = 0; atn = 0; dbus_in = 0;
   endtask

   task automatic send_cmd(input logic [7:0] c[$]);
      foreach (c[i]) send_byte(c[i]);
   endtask

   task automatic finish_cmd(input int st, input string tag);
      logic [7:0] b;
      wait_req();
      chk({tag, " status phase"}, phase, 3);
      get_byte(b);
      chk({tag, " status byte"}, b, st);
      wait_req();
      chk("R11 message-in phase", phase, 7);
      get_byte(b);
      chk("R11 message byte", b, st);
      chk("R11 bus released", bsy, 0);
   endtask

   initial begin
      logic [7:0] cq[$];
      logic [7:0] b;
      int errs;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset bsy", bsy, 0);
      chk("R1 reset req", req, 0);
      chk("R1 reset dma_req", dma_req, 0);
      chk("R1 reset phase", phase, 0);

      // foreign ID
      dbus_in = 8'h80; sel = 1;
      repeat (5) @(negedge clk);
      chk("R2 foreign ID ignored", bsy, 0);
      sel = 0; dbus_in = 0;
      @(negedge clk);

      // attention path, test unit ready
      select(1);
      wait_req();
      chk("R2 message-out phase", phase, 6);
      send_byte(8'hC0);
      wait_req();
      chk("R3 command after message", phase, 2);
      cq = '{8'h00, 0, 0, 0, 0, 0};
      send_cmd(cq);
      finish_cmd(0, "R7 test unit ready");

      // read capacity
      select(0);
      wait_req();
      chk("R2 command phase without atn", phase, 2);
      cq = '{8'h25, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      send_cmd(cq);
      errs = 0;
      for (int i = 0; i < 8; i++) begin
         dma_in(b);
         if (b != ((i == 1) ? 8'h01 : (i == 6) ? 8'h02 : 8'h00)) errs++;
      end
      chk("R8 capacity bytes wrong", errs, 0);
      finish_cmd(0, "R8");

      // READ(6) with store attached
      med_present = 1;
      select(0);
      cq = '{8'h08, 8'hE1, 8'h02, 8'h03, 8'h01, 8'h00};
      send_cmd(cq);
      while (!dma_req) @(negedge clk);
      chk("R5 read6 phase", phase, 1);
      chk("R5 read6 lba", med_lba, 32'h0001_0203);
      errs = 0;
      for (int i = 0; i < 512; i++) begin
         dma_in(b);
         if (b != 8'(8'h03 + i)) errs++;
      end
      chk("R13 read6 store bytes wrong", errs, 0);
      finish_cmd(0, "R10 read6 end");

      // READ(10) without store
      med_present = 0;
      select(0);
      cq = '{8'h28, 0, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0, 8'h01, 0};
      send_cmd(cq);
      while (!dma_req) @(negedge clk);
      chk("R6 read10 lba", med_lba, 32'h1122_3344);
      errs = 0;
      for (int i = 0; i < 512; i++) begin
         dma_in(b);
         if (b != 8'h00) errs++;
      end
      chk("R13 absent store not zero", errs, 0);
      finish_cmd(0, "R6 read10");

      // WRITE(10)
      wr_count = 0;
      select(0);
      cq = '{8'h2A, 0, 0, 0, 0, 8'h05, 0, 0, 8'h01, 0};
      send_cmd(cq);
      while (!dma_req) @(negedge clk);
      chk("R6 write10 phase", phase, 0);
      chk("R6 write10 lba", med_lba, 5);
      for (int i = 0; i < 512; i++) dma_out(8'(i ^ 8'h5A));
      chk("R6 write strobes", wr_count, 512);
      chk("R6 last write byte", last_wdata, 8'(511 ^ 8'h5A));
      finish_cmd(0, "R6 write10");

      // MODE SELECT
      wr_count = 0;
      select(0);
      cq = '{8'h15, 0, 0, 0, 8'h03, 0};
      send_cmd(cq);
      while (!dma_req) @(negedge clk);
      chk("R7 mode select phase", phase, 0);
      for (int i = 0; i < 3; i++) dma_out(8'hAA);
      chk("R7 mode select no store write", wr_count, 0);
      finish_cmd(0, "R7 mode select");

      // INQUIRY on LUN 1
      select(0);
      cq = '{8'h12, 8'h20, 0, 0, 8'h04, 0};
      send_cmd(cq);
      errs = 0;
      for (int i = 0; i < 4; i++) begin
         dma_in(b);
         if (b != 0) errs++;
      end
      chk("R9 inquiry data", errs, 0);
      finish_cmd(2, "R9 inquiry bad LUN");

      // unsupported 10-byte opcode
      select(0);
      cq = '{8'h2F, 0, 0, 0, 0, 0, 0, 0, 0};
      send_cmd(cq);
      wait_req();
      chk("R4 group1 still collecting at 9", phase, 2);
      send_byte(8'h00);
      finish_cmd(2, "R9 unsupported");

      // group 5, 12 bytes
      select(0);
      cq = '{8'hA8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      send_cmd(cq);
      wait_req();
      chk("R4 group5 still collecting at 11", phase, 2);
      send_byte(8'h00);
      finish_cmd(2, "R4 group5");

      // reserved group
      select(0);
      cq = '{8'h60, 0, 0, 0, 0, 0};
      send_cmd(cq);
      finish_cmd(2, "R4 reserved group");

      // zero-length MODE SENSE goes to status, status preset good again
      select(0);
      cq = '{8'h1A, 0, 0, 0, 8'h00, 0};
      send_cmd(cq);
      finish_cmd(0, "R10 zero length");

      // REQUEST SENSE two bytes
      select(0);
      cq = '{8'h03, 0, 0, 0, 8'h02, 0};
      send_cmd(cq);
      for (int i = 0; i < 2; i++) dma_in(b);
      chk("R7 request sense data", b, 0);
      finish_cmd(0, "R7 request sense");

      // bus reset mid-command
      select(0);
      send_byte(8'h28);
      send_byte(8'h00);
      bus_rst = 1;
      @(negedge clk);
      bus_rst = 0;
      chk("R12 bsy after bus reset", bsy, 0);
      chk("R12 req after bus reset", req, 0);
      chk("R12 phase after bus reset", phase, 0);
      select(0);
      cq = '{8'h00, 0, 0, 0, 0, 0};
      send_cmd(cq);
      finish_cmd(0, "R12 fresh command");

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule